// File: doc/BRIEF.md
# Maskable Calendar Alarm Comparator

This block keeps one 32-bit alarm word and, on each one-second strobe, compares it with the running BCD calendar supplied on its inputs. Every field (seconds, minutes, hours with a PM marker, day) carries its own "don't care" bit. A field with that bit set takes no part in the comparison. The day field can be compared either as a day of the month or, when its select bit is set, as a weekday. Month and year are never compared.

A successful comparison sets a sticky hit flag. The flag stays set until software writes a zero to it. A registered interrupt line follows the flag whenever the interrupt enable bit is set. The comparison itself only runs while the arm bit is set.

Reprogramming follows a fixed handshake. Software clears the arm bit, then waits for the write-allowed output to rise a few cycles later, then writes the new alarm word. Writes to the alarm word at any other time are dropped. Setting the arm bit again locks the word at once.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, `hit_flag`, `irq`, `wr_ok` and `alarm_q` are all 0. The arm bit and the interrupt enable bit are both 0.
- R2: The alarm word has this layout:
  - BCD seconds in bits 6:0, minutes in bits 14:8, hours in bits 21:16.
  - PM marker in bit 22.
  - Day of month in bits 29:24.
  - In the edge where `tick` is 1 and the arm bit is set, the flag is set when every unmasked field equals its calendar input. The hour field counts as equal only if both the hours and the PM bit equal `cur_hour` and `cur_pm`.
  - `hit_flag` reads 1 after that edge.
- R3: Bits 7, 15, 23 and 31 are the ignore bits of seconds, minutes, hours (together with PM) and day. A field whose ignore bit is set matches whatever its input holds.
- R4: When bit 30 is set, the day field matches only when bits 27:24 equal `{1'b0, cur_wday}`. Bits 29:28 and `cur_mday` are then ignored.
- R5: No flag is set in an edge where `tick` is 0, or where the arm bit is 0, even if all fields match.
- R6: Writing the status select with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 leaves the flag unchanged. Once set, the flag stays set through further matches. A match in the same edge as a clear leaves the flag set.
- R7: `irq` is 1 exactly when the flag is set and the interrupt enable bit is set, in the same cycle as the flag.
- R8: The register port uses these selects:
  - Select 0 is control: bit 0 is arm, bit 1 is interrupt enable.
  - Select 1 is the alarm word.
  - Select 2 is the status word.
  - With the arm bit 0, `wr_ok` rises `SYNC_DLY` (default 2) edges after the edge that cleared arm, or after reset release.
  - `wr_ok` falls in the same edge that writes arm to 1.
- R9: A write to select 1 updates `alarm_q` only while `wr_ok` is 1. Otherwise the word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe once per second |
| cur_sec | input | 7 | Current BCD seconds |
| cur_min | input | 7 | Current BCD minutes |
| cur_hour | input | 6 | Current BCD hours |
| cur_pm | input | 1 | Current PM marker |
| cur_mday | input | 6 | Current BCD day of month |
| cur_wday | input | 3 | Current weekday 1..7 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 control, 1 alarm word, 2 status) |
| wr_data | input | 32 | Register write data |
| hit_flag | output | 1 | Sticky alarm hit flag |
| wr_ok | output | 1 | Alarm word writes allowed |
| irq | output | 1 | Alarm interrupt |
| alarm_q | output | 32 | Alarm word readback |

## Verification
The assertions watch the following on every cycle:
- The interrupt never appears without the flag.
- A new flag only follows a strobe.
- The flag holds unless a clearing write arrives.
- The alarm word does not move under a locked write.
- Arming always drops the write-allowed output.

Only the bench scenarios can show whether a given alarm word and calendar value should match at all. That covers the mask bits, the weekday select, the PM comparison, the exact rise time of the write-allowed output, and the rule that a clear loses to a simultaneous hit.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int WORD_W    = 32;
  localparam int FLD_W     = 7;
  localparam int N_FLD     = 4;
  localparam int SEC_LSB   = 0;
  localparam int SEC_IGN   = 7;
  localparam int MIN_LSB   = 8;
  localparam int MIN_IGN   = 15;
  localparam int HR_LSB    = 16;
  localparam int PM_BIT    = 22;
  localparam int HR_IGN    = 23;
  localparam int DAY_LSB   = 24;
  localparam int WDSEL_BIT = 30;
  localparam int DAY_IGN   = 31;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_WORD = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] want,
  input  logic [W-1:0] have,
  input  logic         ign,
  output logic         hit
);
  always_comb hit = ign || (want == have);
endmodule

// File: rtl/alarm_wr_gate.sv
module alarm_wr_gate #(
  parameter int SYNC_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_q,
  input  logic arm_nxt,
  output logic wr_ok
);
  localparam int CNT_W = $clog2(SYNC_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SYNC_DLY);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                   cnt_q <= '0;
    else if (arm_q || arm_nxt) cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  always_comb wr_ok = (cnt_q == CNT_TOP);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_req,
  input  logic ie_nxt,
  output logic flag_q,
  output logic irq_q
);
  logic flag_nxt;

  always_comb flag_nxt = set_ev || (flag_q && !clr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt && ie_nxt;
    end
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int SYNC_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic              cur_pm,
  input  logic [5:0]        cur_mday,
  input  logic [2:0]        cur_wday,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic              hit_flag,
  output logic              wr_ok,
  output logic              irq,
  output logic [WORD_W-1:0] alarm_q
);
  reg_sel_e sel;
  logic arm_q, ie_q, arm_nxt, ie_nxt;
  logic ctrl_wr, word_wr, clr_req, set_ev;
  logic [FLD_W-1:0] f_want [N_FLD];
  logic [FLD_W-1:0] f_have [N_FLD];
  logic [N_FLD-1:0] f_ign, f_hit;
  logic wdsel;

  always_comb begin
    sel     = reg_sel_e'(wr_sel);
    ctrl_wr = wr_en && (sel == SEL_CTRL);
    word_wr = wr_en && (sel == SEL_WORD) && wr_ok;
    clr_req = wr_en && (sel == SEL_STAT) && !wr_data[0];
    arm_nxt = ctrl_wr ? wr_data[0] : arm_q;
    ie_nxt  = ctrl_wr ? wr_data[1] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= 1'b0;
      ie_q    <= 1'b0;
      alarm_q <= '0;
    end else begin
      arm_q <= arm_nxt;
      ie_q  <= ie_nxt;
      if (word_wr) alarm_q <= wr_data;
    end
  end

  // field extraction: index 0 sec, 1 min, 2 hour+pm, 3 day
  always_comb begin
    wdsel     = alarm_q[WDSEL_BIT];
    f_want[0] = alarm_q[SEC_LSB +: 7];
    f_have[0] = cur_sec;
    f_want[1] = alarm_q[MIN_LSB +: 7];
    f_have[1] = cur_min;
    f_want[2] = {alarm_q[PM_BIT], alarm_q[HR_LSB +: 6]};
    f_have[2] = {cur_pm, cur_hour};
    f_want[3] = wdsel ? {3'b000, alarm_q[DAY_LSB +: 4]} : {1'b0, alarm_q[DAY_LSB +: 6]};
    f_have[3] = wdsel ? {4'b0000, cur_wday} : {1'b0, cur_mday};
    f_ign     = {alarm_q[DAY_IGN], alarm_q[HR_IGN], alarm_q[MIN_IGN], alarm_q[SEC_IGN]};
  end

  for (genvar g = 0; g < N_FLD; g++) begin : g_fld
    alarm_field_cmp #(.W(FLD_W)) u_cmp (
      .want (f_want[g]),
      .have (f_have[g]),
      .ign  (f_ign[g]),
      .hit  (f_hit[g])
    );
  end

  always_comb set_ev = tick && arm_q && (&f_hit);

  alarm_wr_gate #(.SYNC_DLY(SYNC_DLY)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .arm_q   (arm_q),
    .arm_nxt (arm_nxt),
    .wr_ok   (wr_ok)
  );

  alarm_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set_ev  (set_ev),
    .clr_req (clr_req),
    .ie_nxt  (ie_nxt),
    .flag_q  (hit_flag),
    .irq_q   (irq)
  );
endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        hit_flag,
  input logic        wr_ok,
  input logic        irq,
  input logic [31:0] alarm_q
);
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> hit_flag);

  p_flag_only_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_flag) |-> $past(tick));

  p_sticky_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (hit_flag && !(wr_en && wr_sel == 2'd2 && !wr_data[0])) |=> hit_flag);

  p_locked_word_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1 && !wr_ok) |=> $stable(alarm_q));

  p_arm_drops_ok_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && wr_data[0]) |=> !wr_ok);
endmodule

bind cal_alarm_match cal_alarm_match_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .hit_flag (hit_flag),
  .wr_ok    (wr_ok),
  .irq      (irq),
  .alarm_q  (alarm_q)
);

// File: tb/cal_alarm_match_test.sv
`timescale 1ns/1ps
module cal_alarm_match_test;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [6:0] cur_sec = '0, cur_min = '0;
  logic [5:0] cur_hour = '0, cur_mday = '0;
  logic cur_pm = 1'b0;
  logic [2:0] cur_wday = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic hit_flag, wr_ok, irq;
  logic [31:0] alarm_q;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cal_alarm_match #(.SYNC_DLY(2)) uut (
    .clk(clk), .rst(rst), .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_pm(cur_pm), .cur_mday(cur_mday), .cur_wday(cur_wday),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hit_flag(hit_flag), .wr_ok(wr_ok), .irq(irq), .alarm_q(alarm_q));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected match from the requirement text (R2, R3, R4)
  function automatic bit exp_hit(input logic [31:0] w, input logic [6:0] s, input logic [6:0] m,
                                 input logic [5:0] h, input logic pm, input logic [5:0] md,
                                 input logic [2:0] wd);
    bit ok_s, ok_m, ok_h, ok_d;
    ok_s = w[7]  || (w[6:0] == s);
    ok_m = w[15] || (w[14:8] == m);
    ok_h = w[23] || ((w[21:16] == h) && (w[22] == pm));
    if (w[31])      ok_d = 1;
    else if (w[30]) ok_d = (w[27:24] == {1'b0, wd});
    else            ok_d = (w[29:24] == md);
    return ok_s && ok_m && ok_h && ok_d;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_now(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                         input logic pm, input logic [5:0] md, input logic [2:0] wd);
    cur_sec = s; cur_min = m; cur_hour = h; cur_pm = pm; cur_mday = md; cur_wday = wd;
  endtask

  // disarm, wait for write permission, load word, clear flag, arm
  task automatic prog(input logic [31:0] w, input logic ie);
    wr(2'd0, {30'd0, ie, 1'b0});
    repeat (2) @(negedge clk);
    wr(2'd1, w);
    wr(2'd2, 32'd0);
    wr(2'd0, {30'd0, ie, 1'b1});
  endtask

  task automatic strobe();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [6:0] s, m;
    logic [5:0] h, md;
    logic pm;
    logic [2:0] wd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flag", hit_flag, 0); chk("R1 irq", irq, 0);
    chk("R1 wr_ok", wr_ok, 0);   chk("R1 word", alarm_q, 0);
    rst = 1'b0;
    @(negedge clk); chk("R8 wr_ok one edge after reset", wr_ok, 0);
    @(negedge clk); chk("R8 wr_ok two edges after reset", wr_ok, 1);

    // R9 write allowed, then locked after arming (R8)
    wr(2'd1, 32'h1234_5678); chk("R9 word written", alarm_q, 32'h1234_5678);
    wr(2'd0, 32'd1);         chk("R8 arm drops wr_ok", wr_ok, 0);
    wr(2'd1, 32'hDEAD_BEEF); chk("R9 locked write ignored", alarm_q, 32'h1234_5678);
    wr(2'd0, 32'd0);         chk("R8 wr_ok still low at clear", wr_ok, 0);
    @(negedge clk);          chk("R8 wr_ok low after 1", wr_ok, 0);
    @(negedge clk);          chk("R8 wr_ok high after 2", wr_ok, 1);

    // R2 exact match: 07 Tue? day 15, 10:30:45 PM
    set_now(7'h45, 7'h30, 6'h10, 1'b1, 6'h15, 3'd2);
    prog(32'h1550_3045 | (32'd1 << 22), 1'b0);
    strobe(); chk("R2 exact match", hit_flag, 1); chk("R7 irq off w/o enable", irq, 0);
    // R2 seconds differ
    prog(32'h1550_3046 | (32'd1 << 22), 1'b0);
    strobe(); chk("R2 seconds mismatch", hit_flag, 0);
    // R2 PM differs
    prog(32'h1510_3045, 1'b0);
    strobe(); chk("R2 pm mismatch", hit_flag, 0);
    // R3 seconds ignored
    prog(32'h1550_30C6 | (32'd1 << 22), 1'b0);
    strobe(); chk("R3 seconds ignored", hit_flag, 1);
    // R3 day ignored, hour ignored
    prog(32'h8080_3045 | (32'h00 << 24), 1'b0);
    strobe(); chk("R3 day and hour ignored", hit_flag, 1);
    // R4 weekday select: bits 27:24 = 2, 29:28 garbage
    prog(32'h7250_3045, 1'b0);
    strobe(); chk("R4 weekday match", hit_flag, 1);
    prog(32'h7350_3045, 1'b0);
    strobe(); chk("R4 weekday mismatch", hit_flag, 0);

    // R5 no tick, and disarmed
    prog(32'hFFFF_FFFF, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 no tick no flag", hit_flag, 0);
    wr(2'd0, 32'd0);
    strobe(); chk("R5 disarmed no flag", hit_flag, 0);

    // R6 sticky behaviour, R7 irq
    prog(32'hFFFF_FFFF, 1'b1);
    strobe(); chk("R6 set", hit_flag, 1); chk("R7 irq with enable", irq, 1);
    strobe(); chk("R6 stays on rematch", hit_flag, 1);
    wr(2'd2, 32'd1); chk("R6 write one keeps flag", hit_flag, 1);
    wr(2'd0, 32'd1); chk("R7 irq off when disabled", irq, 0); chk("R6 flag kept", hit_flag, 1);
    wr(2'd0, 32'd3); chk("R7 irq back on", irq, 1);
    wr(2'd2, 32'd0); chk("R6 cleared", hit_flag, 0); chk("R7 irq follows clear", irq, 0);
    // R6 set wins over simultaneous clear
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'd0;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R6 set beats clear", hit_flag, 1);

    // random vectors R2/R3/R4
    for (int i = 0; i < 300; i++) begin
      s = 7'($urandom); m = 7'($urandom); h = 6'($urandom); pm = 1'($urandom);
      md = 6'($urandom); wd = 3'($urandom);
      w = {1'b0, 1'b0, md, 1'b0, pm, h, 1'b0, m, 1'b0, s};
      if ($urandom % 2) w[30] = 1'b1;
      if (w[30]) w[27:24] = {1'b0, wd};
      for (int k = 0; k < 4; k++) if ($urandom % 4 == 0) w[7 + 8 * k] = 1'b1;
      if ($urandom % 2) w = w ^ (32'd1 << ($urandom % 32));
      set_now(s, m, h, pm, md, wd);
      prog(w, 1'($urandom));
      strobe();
      chk($sformatf("R2/R3/R4 random %0d", i), hit_flag, exp_hit(w, s, m, h, pm, md, wd));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule